// File: doc/BRIEF.md
# Reloadable Down-Counting Timer

This block is a bus-attached 32-bit timer that counts down from a programmed value. Software sets it up through three 32-bit words: a control word, a write-only load word and a read-only count word. The control word has separate bits for clock enable and run, a bit that selects auto-reload, and a three-bit prescaler field. When clock enable and run are both set, the count falls by one on every prescaled tick. The prescaler divides the input clock by 2^(field+1), so the lowest setting already halves the clock.

When the count reaches zero the block sends out a one-clock interrupt pulse. In auto-reload mode the count is then refilled from the load word, which gives a period of load+1 ticks. In one-shot mode the run bit clears itself and the count stays at zero. The usual setup is three writes: clock enable alone, then the load value, then clock enable with run and, if wanted, auto-reload. Any control write with the run bit set copies the load value into the count. If the load value is all ones and auto-reload is on, the timer runs freely, and the bitwise complement of its count is an up-counting timestamp. Each instance decodes only the low eight address bits, so several copies can be placed 0x100 bytes apart.

Top module: `dncount_timer`

## Requirements
- R1: After a synchronous active-low reset, the control word, the load word and the count are all zero, and the interrupt output is low.
- R2: Only word-aligned offsets decode (bus_addr[1:0] must be 0). Offset 0x0 is control: bit 0 run, bit 1 auto-reload, bits 4:2 prescaler field P, bit 5 clock enable, all other bits read 0. Offset 0x4 is the load word; it is write-only and reads 0. Offset 0x8 is the count; it is read-only, and writes to it are ignored. Every other offset reads 0 and ignores writes. Read data is combinational from the address.
- R3: A control write with bit 0 set copies the load word into the count at that clock edge and restarts the prescaler. The new count can be read in the next cycle.
- R4: While clock enable and run are both set, the count decreases by one every 2^(P+1) clocks. The first decrease lands on the 2^(P+1)-th clock edge after the starting write.
- R5: The interrupt output is high for exactly one cycle, in the cycle after a tick that takes the count from 1 to 0. It is also high after a tick that finds the count at 0 while the load word is 0. In both cases the count reads 0 in that same cycle.
- R6: With auto-reload set, a tick at count 0 reloads the count from the load word, so interrupts repeat every (load+1)·2^(P+1) clocks.
- R7: With auto-reload clear, the tick that reaches zero, or a tick that finds the count at zero, clears the run bit. The count then stays at 0 until the timer is restarted.
- R8: Clearing the run bit or the clock enable freezes the count and leaves the other control fields as written. Writing the load word does not change a count that is already running.
- R9: With load all ones, auto-reload set and P=0, the complement of the count equals the number of ticks since start, which is the clocks elapsed divided by 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset within the instance's window |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | One-cycle interrupt pulse when the count expires |

## Verification
Read data depends only on the address and the registered state, so the bench checks it in the same cycle it drives the address, before the next edge. A register write, a start or a tick takes effect at one clock edge. The bench therefore steps its model once per edge and compares the count in the following cycle. The interrupt comes from a register loaded on the tick edge, so it is compared in the cycle right after that edge, together with the count of zero. Directed cases count the exact number of cycles from the starting write to the first interrupt and between interrupts (2^(P+1) per tick). Random traffic is compared against the model on every cycle.

// File: rtl/timer_pkg.sv
// Package: shared constants and the control-word layout for the down-counting timer.
// Assumes a 32-bit bus and word-aligned register offsets.
package timer_pkg;
    localparam int DATA_W = 32;
    localparam int PTV_W  = 3;

    // Word indices within the instance window (byte offset / 4)
    localparam int WORD_CTRL  = 0;
    localparam int WORD_LOAD  = 1;
    localparam int WORD_COUNT = 2;

    // Control word, packed MSB first so bit 0 is run and bit 5 is clock enable
    typedef struct packed {
        logic             clk_en;
        logic [PTV_W-1:0] ptv;
        logic             autoreload;
        logic             run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/timer_regs.sv
// Module: register window. Holds the control and load words, decodes the bus,
// and produces the start pulse and the combinational read data.
// Assumes writes and reads are single-cycle; offsets that are not word-aligned never decode.
module timer_regs
    import timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              oneshot_done,
    input  logic [CNT_W-1:0]  count_val,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  load_val,
    output logic              start_pulse,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              wr_ctrl;
    logic              wr_load;
    logic              wr_count;

    // Decode the word index and the write strobes
    always_comb begin
        word     = bus_addr[ADDR_W-1:2];
        aligned  = (bus_addr[1:0] == 2'b00);
        wr_ctrl  = bus_we && aligned && (word == WORD_W'(WORD_CTRL));
        wr_load  = bus_we && aligned && (word == WORD_W'(WORD_LOAD));
        wr_count = bus_we && aligned && (word == WORD_W'(WORD_COUNT));
    end

    assign start_pulse = wr_ctrl && bus_wdata[0];

    // Control word: a bus write takes priority over the one-shot self-clear of run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end else if (oneshot_done) begin
            ctrl.run <= 1'b0;
        end
    end

    // Load word: written only through its own offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_val <= '0;
        end else if (wr_load) begin
            load_val <= bus_wdata[CNT_W-1:0];
        end
    end

    // Read mux: control and count are visible, everything else reads zero
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (word == WORD_W'(WORD_CTRL)) begin
                bus_rdata = DATA_W'(ctrl);
            end else if (word == WORD_W'(WORD_COUNT)) begin
                bus_rdata = DATA_W'(count_val);
            end
        end
    end

    // R2: a write to the count offset leaves the load word untouched
    a_r2_count_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count |=> $stable(load_val));

    // R7: the one-shot expiry clears run unless software rewrites control in the same cycle
    a_r7_done_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
        (oneshot_done && !wr_ctrl) |=> !ctrl.run);
endmodule

// File: rtl/timer_prescale.sv
// Module: prescaler. Produces a one-cycle tick every 2^(ptv+1) clocks while running.
// Assumes a restart clears the phase, so the first tick comes a full period after the start.
module timer_prescale
    import timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             restart,
    input  logic [PTV_W-1:0] ptv,
    output logic             tick
);
    localparam int PRE_W = 2 ** PTV_W;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    assign limit = PRE_W'((32'd2 << ptv) - 32'd1);
    assign tick  = running && !restart && (pre_q == limit);

    // Phase counter: held at zero when idle or restarted, wraps at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!running || restart || (pre_q == limit)) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R4: the divider is at least two, so ticks never come back to back
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/timer_core.sv
// Module: count register with reload, one-shot stop and the interrupt pulse.
// Assumes tick and start_pulse never occur together (the prescaler suppresses tick on a start).
module timer_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start_pulse,
    input  logic             autoreload,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             oneshot_done
);
    logic at_one;
    logic at_zero;
    logic expire;

    // Classify the current count and detect the expiry events
    always_comb begin
        at_one       = (count == CNT_W'(1));
        at_zero      = (count == '0);
        expire       = tick && (at_one || (at_zero && (load_val == '0)));
        oneshot_done = tick && !autoreload && (at_one || at_zero);
    end

    // Count register: load on start, reload or hold at zero, otherwise decrement per tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (start_pulse) begin
            count <= load_val;
        end else if (tick) begin
            if (at_zero) begin
                count <= autoreload ? load_val : '0;
            end else begin
                count <= count - 1'b1;
            end
        end
    end

    // Interrupt register: one-cycle pulse after an expiring tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= expire;
        end
    end

    // R3: a start copies the load word into the count
    a_r3_start_copies_load: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> (count == $past(load_val)));

    // R8: without a tick or a start the count does not move
    a_r8_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_pulse && !tick) |=> $stable(count));

    // R4: a tick on a non-zero count takes exactly one off it
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !at_zero) |=> (count == $past(count) - CNT_W'(1)));

    // R5: the interrupt lasts one cycle and lines up with a zero count
    a_r5_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    a_r5_irq_with_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count == '0));

    // R7: in one-shot mode a tick at zero keeps the count at zero
    a_r7_oneshot_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !autoreload && at_zero) |=> (count == '0));
endmodule

// File: rtl/dncount_timer.sv
// Module: top of the reloadable down-counting timer. Wires the register window,
// the prescaler and the count core together.
// Assumes a single clock domain; the bus sees one instance per 0x100-byte window.
module dncount_timer
    import timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] count_val;
    logic             start_pulse;
    logic             oneshot_done;
    logic             tick;
    logic             running;

    assign running = ctrl.clk_en && ctrl.run;

    timer_regs #(
        .CNT_W (CNT_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .oneshot_done(oneshot_done),
        .count_val   (count_val),
        .ctrl        (ctrl),
        .load_val    (load_val),
        .start_pulse (start_pulse),
        .bus_rdata   (bus_rdata)
    );

    timer_prescale u_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .running(running),
        .restart(start_pulse),
        .ptv    (ctrl.ptv),
        .tick   (tick)
    );

    timer_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .start_pulse (start_pulse),
        .autoreload  (ctrl.autoreload),
        .load_val    (load_val),
        .count       (count_val),
        .irq         (irq),
        .oneshot_done(oneshot_done)
    );

    // R8: no tick is issued unless both clock enable and run are set
    a_r8_tick_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (ctrl.clk_en && ctrl.run));
endmodule

// File: tb/dncount_timer_bench.sv
`timescale 1ns/1ps
module dncount_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference state, advanced once per clock edge
    bit          m_ce, m_ar, m_st;
    bit [2:0]    m_ptv;
    bit [31:0]   m_load, m_cnt;
    int unsigned m_pre;
    bit          m_irq;
    bit          irq_seen;

    dncount_timer u_dncount_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [31:0] exp_read(input bit [7:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a[7:2])
            6'd0:    return {26'h0, m_ce, m_ptv, m_ar, m_st};
            6'd2:    return m_cnt;
            default: return 32'h0;
        endcase
    endfunction

    // Advance the reference by one clock edge for the given bus inputs (R2..R7)
    task automatic model_step(input bit [7:0] a, input bit w, input bit [31:0] d);
        bit wr_ctrl, wr_load, sp, run, tk, done;
        int unsigned lim;
        wr_ctrl = w && a == 8'h00;
        wr_load = w && a == 8'h04;
        sp   = wr_ctrl && d[0];
        run  = m_ce && m_st;
        lim  = (2 << m_ptv) - 1;
        tk   = run && !sp && (m_pre == lim);
        m_irq = tk && (m_cnt == 1 || (m_cnt == 0 && m_load == 0));
        done = tk && !m_ar && (m_cnt <= 1);
        if (!run || sp || m_pre == lim) m_pre = 0; else m_pre++;
        if (sp) m_cnt = m_load;
        else if (tk) m_cnt = (m_cnt == 0) ? (m_ar ? m_load : 32'h0) : m_cnt - 1;
        if (wr_ctrl) begin
            m_st = d[0]; m_ar = d[1]; m_ptv = d[4:2]; m_ce = d[5];
        end else if (done) begin
            m_st = 0;
        end
        if (wr_load) m_load = d;
    endtask

    // One cycle: drive at the falling edge, check read data, step, check irq a cycle later
    task automatic cycle(input bit [7:0] a, input bit w, input bit [31:0] d);
        string tag;
        bus_addr = a; bus_we = w; bus_wdata = d;
        #1;
        tag = (a == 8'h08) ? "R4 count read" : "R2 register read";
        check(tag, bus_rdata, exp_read(a));
        model_step(a, w, d);
        @(negedge clk);
        check("R5 irq", {31'h0, irq}, {31'h0, m_irq});
        irq_seen = irq;
    endtask

    task automatic idle(input int n, output int irqs, output int first_at);
        irqs = 0; first_at = -1;
        for (int i = 1; i <= n; i++) begin
            cycle(8'h08, 0, 32'h0);
            if (irq_seen) begin
                irqs++;
                if (first_at < 0) first_at = i;
            end
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : stim
        int n, first;
        bit [31:0] held;
        void'($urandom(32'd1357));
        m_ce = 0; m_ar = 0; m_st = 0; m_ptv = 0; m_load = 0; m_cnt = 0; m_pre = 0; m_irq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every word and the interrupt
        bus_addr = 8'h00; #1 check("R1 ctrl reset", bus_rdata, 32'h0);
        bus_addr = 8'h08; #1 check("R1 count reset", bus_rdata, 32'h0);
        check("R1 irq reset", {31'h0, irq}, 32'h0);
        @(negedge clk);

        // R2: load is write-only, count ignores writes, unused and unaligned read zero
        cycle(8'h04, 1, 32'h0000_0003);
        cycle(8'h04, 0, 32'h0);
        check("R2 load reads zero", bus_rdata, 32'h0);
        cycle(8'h08, 1, 32'h0000_0055);
        check("R2 count write ignored", bus_rdata, 32'h0);
        cycle(8'h0C, 0, 32'h0);
        cycle(8'h01, 0, 32'h0);

        // R3, R4, R5, R7: one-shot, load 3, P=0 -> irq 6 clocks after the start
        cycle(8'h00, 1, 32'h0000_0020);
        cycle(8'h00, 1, 32'h0000_0021);
        bus_addr = 8'h08; #1 check("R3 start copies load", bus_rdata, 32'd3);
        @(negedge clk); m_pre = m_pre; // keep alignment: this idle cycle matches model below
        model_step(8'h08, 0, 32'h0);
        idle(40, n, first);
        check("R5 one-shot first irq cycle", first + 1, 32'd6);
        check("R7 one-shot single irq", n, 32'd1);
        cycle(8'h00, 0, 32'h0);
        check("R7 run bit cleared", bus_rdata, 32'h0000_0020);

        // R6: periodic, load 4, P=1 -> irqs at 16, 36, ... within 200 clocks
        cycle(8'h04, 1, 32'd4);
        cycle(8'h00, 1, 32'h0000_0027);
        idle(200, n, first);
        check("R6 periodic first irq", first, 32'd16);
        check("R6 periodic irq count", n, 32'd10);

        // R8: clearing run freezes the count and keeps other fields; load write has no effect
        cycle(8'h00, 1, 32'h0000_0026);
        cycle(8'h08, 0, 32'h0);
        held = bus_rdata;
        idle(30, n, first);
        cycle(8'h08, 0, 32'h0);
        check("R8 count frozen", bus_rdata, held);
        cycle(8'h00, 0, 32'h0);
        check("R8 fields kept", bus_rdata, 32'h0000_0026);
        cycle(8'h00, 1, 32'h0000_0023);
        cycle(8'h04, 1, 32'd100);
        idle(6, n, first);
        check("R8 load write mid-run", bus_rdata, 32'd1);

        // R5: load 0 periodic, P=0 -> an irq every 2 clocks
        cycle(8'h04, 1, 32'd0);
        cycle(8'h00, 1, 32'h0000_0023);
        idle(20, n, first);
        check("R5 zero-load irq count", n, 32'd10);

        // R9: free-running timestamp
        cycle(8'h04, 1, 32'hFFFF_FFFF);
        cycle(8'h00, 1, 32'h0000_0023);
        idle(199, n, first);
        cycle(8'h08, 0, 32'h0);
        check("R9 complement is elapsed ticks", ~bus_rdata, 32'd100);

        // Random traffic against the reference model
        for (int i = 0; i < 20000; i++) begin
            bit [7:0]  a;
            bit        w;
            bit [31:0] d;
            int r;
            r = $urandom_range(0, 99);
            case ($urandom_range(0, 5))
                0, 1: a = 8'h00;
                2:    a = 8'h04;
                3:    a = 8'h08;
                4:    a = 8'h0C;
                default: a = 8'($urandom_range(0, 255));
            endcase
            w = (r < 4);
            d = $urandom();
            if (w && a == 8'h04) d = ($urandom_range(0, 9) == 0) ? d : 32'($urandom_range(0, 12));
            if (w && a == 8'h00) begin
                d[4:2] = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(3, 7)) : 3'($urandom_range(0, 2));
                d[5]   = ($urandom_range(0, 7) != 0);
            end
            cycle(a, w, d);
        end

        finish_run();
    end
endmodule